// File: doc/BRIEF.md
# Interrupt Acceptance and Mode Controller

This block sits beside the instruction sequencer of an 8-bit processor core. It decides whether a pending interrupt is taken at an instruction boundary and, when one is taken, says where the program counter goes next. It holds the two interrupt-enable flip-flops (a primary enable that gates maskable requests and a shadow copy that survives a non-maskable entry) and a register for the maskable-interrupt mode, which has three values. The sequencer supplies decoded strobes for enable, disable, mode-set and return-from-NMI. It also supplies the interrupt-vector register and the byte placed on the bus by the interrupting device.

When a request is accepted, the block raises a one-cycle accept pulse together with a push-PC strobe, a program-counter source code, a 16-bit target address and the cycle cost of the entry. In mode 0 the device byte is itself an opcode. The block only reports this case and passes the byte on, and the sequencer executes it. The shadow enable is brought out so that instructions which copy the vector or refresh register into the accumulator can put it into the parity/overflow flag.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After synchronous reset, both enable flip-flops read 0, the mode reads 0 and accept_o, push_pc_o, pc_src_o, target_pc_o and cycles_o are all 0.
- R2: An enable strobe sets both enable flip-flops at the next edge and a disable strobe clears both. If both strobes come in the same cycle, disable wins.
- R3: A maskable request is accepted only in a cycle where boundary_i is high and the primary enable reads 1. Otherwise no accept pulse is produced.
- R4: Accepting a maskable request clears both enable flip-flops.
- R5: A non-maskable request at a boundary is always accepted. It clears only the primary enable, leaves the shadow enable unchanged, and produces push 1, source 1, target 0x0066 and cost 13.
- R6: When non-maskable and maskable requests arrive in the same boundary cycle, the non-maskable one is taken. The shadow enable keeps its value.
- R7: A maskable acceptance in mode 1 produces push 1, source 1, target 0x0038 and cost 13.
- R8: A maskable acceptance in mode 2 produces push 1, source 1, target {vec_reg_i, dev_byte_i} (vector register in the high byte) and cost 19.
- R9: A maskable acceptance in mode 0 produces push 0, source 2, target 0 and cost 0, and inject_op_o carries the device byte.
- R10: A return-from-NMI strobe copies the shadow enable into the primary enable.
- R11: A mode-set strobe decodes the 3-bit code im_code_i: codes 0, 1, 4 and 5 select mode 0, codes 2 and 6 select mode 1, codes 3 and 7 select mode 2. mode_o reads 0, 1 or 2.
- R12: The response to a request sampled in one cycle appears in the following cycle and lasts one cycle. Every cycle without an acceptance reads accept 0, push 0, source 0, target 0 and cost 0. Source codes: 0 none, 1 jump to target, 2 inject device opcode.
- R13: In a cycle where an acceptance occurs, its effect on the enable flip-flops overrides any enable, disable or return-from-NMI strobe given in the same cycle. A same-cycle mode-set still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction-boundary strobe; requests are sampled only here |
| nmi_req_i | input | 1 | Non-maskable request |
| int_req_i | input | 1 | Maskable request |
| vec_reg_i | input | 8 | Interrupt-vector register (mode 2 high byte) |
| dev_byte_i | input | 8 | Byte supplied by interrupting device |
| ei_i | input | 1 | Decoded enable-interrupts strobe |
| di_i | input | 1 | Decoded disable-interrupts strobe |
| im_set_i | input | 1 | Decoded mode-set strobe |
| im_code_i | input | 3 | Mode-set code field |
| retn_i | input | 1 | Decoded return-from-NMI strobe |
| accept_o | output | 1 | One-cycle acceptance pulse |
| push_pc_o | output | 1 | Push current PC request |
| pc_src_o | output | 2 | New PC source: 0 none, 1 target, 2 injected opcode |
| target_pc_o | output | 16 | Target program counter |
| cycles_o | output | 5 | Cycle cost of the entry |
| inject_op_o | output | 8 | Device opcode for mode 0 |
| iff1_o | output | 1 | Primary enable flip-flop |
| iff2_o | output | 1 | Shadow enable flip-flop, for the parity/overflow flag |
| mode_o | output | 2 | Current maskable-interrupt mode |

## Verification
A wrong enable flip-flop shows at iff1_o or iff2_o one edge after the strobe or acceptance that set it. It also shows at the next boundary, where a maskable request is taken or refused wrongly. A wrong mode register shows at mode_o at once, and at the first maskable acceptance it gives the wrong push, source, target or cost. The bench sweeps every combination of mode, enable state, request pair and boundary strobe, and decodes all eight mode codes, so each such fault is visible within two cycles of the stimulus that exposes it.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int CYC_W = 5;

    typedef enum logic [1:0] {
        IMODE_0 = 2'd0,
        IMODE_1 = 2'd1,
        IMODE_2 = 2'd2
    } imode_e;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_JUMP   = 2'd1,
        SRC_INJECT = 2'd2
    } pc_src_e;

    typedef enum logic [1:0] {
        TAKE_NONE = 2'd0,
        TAKE_NMI  = 2'd1,
        TAKE_INT  = 2'd2
    } take_e;

    typedef struct packed {
        logic             accept;
        logic             push;
        pc_src_e          src;
        logic [CYC_W-1:0] cycles;
    } resp_ctl_s;

    localparam int NMI_TARGET = 'h0066;
    localparam int IM1_TARGET = 'h0038;
    localparam int CYC_NMI    = 13;
    localparam int CYC_IM1    = 13;
    localparam int CYC_IM2    = 19;

    function automatic imode_e decode_mode(input logic [2:0] code);
        imode_e m;
        case (code[1:0])
            2'b10:   m = IMODE_1;
            2'b11:   m = IMODE_2;
            default: m = IMODE_0;
        endcase
        return m;
    endfunction

    localparam resp_ctl_s RESP_IDLE = '{accept: 1'b0, push: 1'b0,
                                        src: SRC_NONE, cycles: '0};

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_ctrl_pkg::*;
(
    input  logic  boundary,
    input  logic  nmi_req,
    input  logic  int_req,
    input  logic  iff1,
    output take_e take
);
    always_comb begin
        take = TAKE_NONE;
        if (boundary) begin
            if (nmi_req)
                take = TAKE_NMI;
            else if (int_req && iff1)
                take = TAKE_INT;
        end
    end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
    import irq_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  take_e      take,
    input  logic       ei,
    input  logic       di,
    input  logic       retn,
    input  logic       im_set,
    input  logic [2:0] im_code,
    output logic       iff1,
    output logic       iff2,
    output imode_e     mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else begin
            case (take)
                TAKE_NMI: iff1 <= 1'b0;
                TAKE_INT: begin
                    iff1 <= 1'b0;
                    iff2 <= 1'b0;
                end
                default: begin
                    if (di) begin
                        iff1 <= 1'b0;
                        iff2 <= 1'b0;
                    end else if (ei) begin
                        iff1 <= 1'b1;
                        iff2 <= 1'b1;
                    end else if (retn) begin
                        iff1 <= iff2;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode <= IMODE_0;
        else if (im_set)
            mode <= decode_mode(im_code);
    end

    AST_IFF1_IMPLIES_IFF2: assert property (@(posedge clk) disable iff (rst)
        iff1 |-> iff2); // R5
    AST_NMI_CLEARS_PRIMARY: assert property (@(posedge clk) disable iff (rst)
        (take == TAKE_NMI) |=> (!iff1 && iff2 == $past(iff2))); // R5
    AST_INT_CLEARS_BOTH: assert property (@(posedge clk) disable iff (rst)
        (take == TAKE_INT) |=> (!iff1 && !iff2)); // R4
    AST_EI_SETS_BOTH: assert property (@(posedge clk) disable iff (rst)
        (ei && !di && take == TAKE_NONE) |=> (iff1 && iff2)); // R2
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode != imode_e'(2'b11)); // R11
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
    import irq_ctrl_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  take_e             take,
    input  imode_e            mode,
    input  logic [DATA_W-1:0] vec_reg,
    input  logic [DATA_W-1:0] dev_byte,
    output resp_ctl_s         resp,
    output logic [ADDR_W-1:0] target,
    output logic [DATA_W-1:0] inject_op
);
    always_comb begin
        resp      = RESP_IDLE;
        target    = '0;
        inject_op = '0;
        case (take)
            TAKE_NMI: begin
                resp.accept = 1'b1;
                resp.push   = 1'b1;
                resp.src    = SRC_JUMP;
                resp.cycles = CYC_W'(CYC_NMI);
                target      = ADDR_W'(NMI_TARGET);
            end
            TAKE_INT: begin
                resp.accept = 1'b1;
                case (mode)
                    IMODE_1: begin
                        resp.push   = 1'b1;
                        resp.src    = SRC_JUMP;
                        resp.cycles = CYC_W'(CYC_IM1);
                        target      = ADDR_W'(IM1_TARGET);
                    end
                    IMODE_2: begin
                        resp.push   = 1'b1;
                        resp.src    = SRC_JUMP;
                        resp.cycles = CYC_W'(CYC_IM2);
                        target      = {vec_reg, dev_byte};
                    end
                    default: begin
                        resp.src  = SRC_INJECT;
                        inject_op = dev_byte;
                    end
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary_i,
    input  logic              nmi_req_i,
    input  logic              int_req_i,
    input  logic [DATA_W-1:0] vec_reg_i,
    input  logic [DATA_W-1:0] dev_byte_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              im_set_i,
    input  logic [2:0]        im_code_i,
    input  logic              retn_i,
    output logic              accept_o,
    output logic              push_pc_o,
    output logic [1:0]        pc_src_o,
    output logic [ADDR_W-1:0] target_pc_o,
    output logic [CYC_W-1:0]  cycles_o,
    output logic [DATA_W-1:0] inject_op_o,
    output logic              iff1_o,
    output logic              iff2_o,
    output logic [1:0]        mode_o
);
    take_e             take;
    imode_e            mode;
    logic              iff1, iff2;
    resp_ctl_s         resp_d, resp_q;
    logic [ADDR_W-1:0] target_d, target_q;
    logic [DATA_W-1:0] inj_d, inj_q;

    irq_arbiter u_arb (
        .boundary (boundary_i),
        .nmi_req  (nmi_req_i),
        .int_req  (int_req_i),
        .iff1     (iff1),
        .take     (take)
    );

    irq_enable_regs u_en (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .ei      (ei_i),
        .di      (di_i),
        .retn    (retn_i),
        .im_set  (im_set_i),
        .im_code (im_code_i),
        .iff1    (iff1),
        .iff2    (iff2),
        .mode    (mode)
    );

    irq_vector_gen #(.DATA_W(DATA_W)) u_vec (
        .take      (take),
        .mode      (mode),
        .vec_reg   (vec_reg_i),
        .dev_byte  (dev_byte_i),
        .resp      (resp_d),
        .target    (target_d),
        .inject_op (inj_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q   <= RESP_IDLE;
            target_q <= '0;
            inj_q    <= '0;
        end else begin
            resp_q   <= resp_d;
            target_q <= target_d;
            inj_q    <= inj_d;
        end
    end

    assign accept_o    = resp_q.accept;
    assign push_pc_o   = resp_q.push;
    assign pc_src_o    = resp_q.src;
    assign cycles_o    = resp_q.cycles;
    assign target_pc_o = target_q;
    assign inject_op_o = inj_q;
    assign iff1_o      = iff1;
    assign iff2_o      = iff2;
    assign mode_o      = mode;

    AST_ACCEPT_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> $past(boundary_i)); // R3
    AST_PUSH_ONLY_ON_JUMP: assert property (@(posedge clk) disable iff (rst)
        push_pc_o |-> (accept_o && pc_src_o == 2'd1)); // R9
    AST_NMI_WINS: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && nmi_req_i) |=> (accept_o && target_pc_o == ADDR_W'(NMI_TARGET))); // R6
    AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        !accept_o |-> (!push_pc_o && pc_src_o == 2'd0 && cycles_o == '0)); // R12
endmodule

// File: tb/test_irq_accept_ctrl.sv
`timescale 1ns/1ps
module test_irq_accept_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        boundary, nmi, intr, ei, di, im_set, retn;
    logic [7:0]  vec, dev;
    logic [2:0]  im_code;
    logic        accept, push, iff1, iff2;
    logic [1:0]  src, mode;
    logic [15:0] target;
    logic [4:0]  cycles;
    logic [7:0]  inj;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    irq_accept_ctrl i_irq_accept_ctrl (
        .clk(clk), .rst(rst), .boundary_i(boundary), .nmi_req_i(nmi),
        .int_req_i(intr), .vec_reg_i(vec), .dev_byte_i(dev), .ei_i(ei),
        .di_i(di), .im_set_i(im_set), .im_code_i(im_code), .retn_i(retn),
        .accept_o(accept), .push_pc_o(push), .pc_src_o(src),
        .target_pc_o(target), .cycles_o(cycles), .inject_op_o(inj),
        .iff1_o(iff1), .iff2_o(iff2), .mode_o(mode)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        boundary = 0; nmi = 0; intr = 0; ei = 0; di = 0;
        im_set = 0; retn = 0; im_code = 0; vec = 0; dev = 0;
    endtask

    // inputs are driven after a falling edge; one rising edge then samples them
    task automatic tick();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic set_enable(input bit on);
        ei = on; di = !on;
        tick();
    endtask

    task automatic set_mode(input int code);
        im_set = 1; im_code = 3'(code);
        tick();
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "iff1", iff1, 0);
        chk("R1", "iff2", iff2, 0);
        chk("R1", "mode", mode, 0);
        chk("R1", "accept", accept, 0);
        chk("R1", "target", target, 0);

        // R11 all eight mode codes
        for (int c = 0; c < 8; c++) begin
            int em;
            set_mode(c);
            em = ((c & 3) == 2) ? 1 : ((c & 3) == 3) ? 2 : 0;
            chk("R11", "mode decode", mode, em);
        end

        // R2 enable, disable, simultaneous
        set_enable(1);
        chk("R2", "ei iff1", iff1, 1);
        chk("R2", "ei iff2", iff2, 1);
        ei = 1; di = 1; tick();
        chk("R2", "di wins iff1", iff1, 0);
        chk("R2", "di wins iff2", iff2, 0);

        // sweep: mode x enable x requests x boundary
        for (int m = 0; m < 3; m++)
          for (int e = 0; e < 2; e++)
            for (int rq = 0; rq < 4; rq++)
              for (int b = 0; b < 2; b++) begin
                bit nt, it;
                int idx, x_push, x_src, x_tgt, x_cyc, x_inj, x1, x2;
                string tag;
                idx = ((m * 2 + e) * 4 + rq) * 2 + b;
                set_mode(m == 0 ? 4 : (m == 1 ? 6 : 7));
                set_enable(e[0]);
                boundary = b[0]; nmi = rq[1]; intr = rq[0];
                vec = 8'(8'h40 + idx); dev = 8'(idx * 7 + 1);
                nt = b[0] && rq[1];
                it = b[0] && rq[0] && e[0] && !rq[1];
                x_push = 0; x_src = 0; x_tgt = 0; x_cyc = 0; x_inj = 0;
                x1 = e; x2 = e;
                tag = "R3";
                if (nt) begin
                    x_push = 1; x_src = 1; x_tgt = 'h66; x_cyc = 13; x1 = 0;
                    tag = rq[0] ? "R6" : "R5";
                end else if (it) begin
                    x1 = 0; x2 = 0;
                    if (m == 1) begin
                        x_push = 1; x_src = 1; x_tgt = 'h38; x_cyc = 13; tag = "R7";
                    end else if (m == 2) begin
                        x_push = 1; x_src = 1; x_tgt = {vec, dev}; x_cyc = 19; tag = "R8";
                    end else begin
                        x_src = 2; x_inj = dev; tag = "R9";
                    end
                end
                tick();
                chk(tag, "accept", accept, (nt || it) ? 1 : 0);
                chk(tag, "push", push, x_push);
                chk(tag, "src", src, x_src);
                chk(tag, "target", target, x_tgt);
                chk(tag, "cycles", cycles, x_cyc);
                if (it && m == 0) chk("R9", "inject", inj, x_inj);
                chk(it ? "R4" : tag, "iff1", iff1, x1);
                chk(it ? "R4" : tag, "iff2", iff2, x2);
                tick();
                chk("R12", "accept one cycle", accept, 0);
                chk("R12", "idle target", target, 0);
              end

        // R10 return from NMI restores primary enable
        set_enable(1);
        boundary = 1; nmi = 1; tick();
        chk("R5", "nmi iff1", iff1, 0);
        chk("R5", "nmi iff2", iff2, 1);
        retn = 1; tick();
        chk("R10", "retn iff1", iff1, 1);
        set_enable(0);
        retn = 1; tick();
        chk("R10", "retn keeps 0", iff1, 0);

        // R13 acceptance overrides same-cycle enable; mode-set still applies
        set_mode(2);
        set_enable(1);
        boundary = 1; intr = 1; ei = 1; im_set = 1; im_code = 3'd3; tick();
        chk("R13", "accept", accept, 1);
        chk("R13", "target mode1", target, 'h38);
        chk("R13", "iff1", iff1, 0);
        chk("R13", "iff2", iff2, 0);
        chk("R13", "mode set", mode, 2);
        set_enable(1);
        boundary = 1; nmi = 1; retn = 1; tick();
        chk("R13", "nmi over retn iff1", iff1, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule